// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream for a short wrapping burst. A load cycle captures a start address. Each advance cycle after it steps the low address bits through a four-beat pattern, and the pattern returns to the start after the fourth address. Two patterns are available. The first is a wrapping increment. The second is an interleaved order, in which each beat's low bits are the start bits XORed with the beat number. The bits above the burst field are copied from the start address and stay fixed for the whole burst.

A memory controller or address front end uses the block to turn one externally supplied address into the full set of addresses of a burst. The burst length is a parameter and must be a power of two; its default is four. The order-select input is meant to be tied to a fixed level. If it changes in the middle of a burst, the result is undefined. A clock-enable input freezes the sequencer. All outputs come from registers.

Top module: `burst_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `burst_addr` = 0 and `beat_idx` = 0.
- R2: A cycle with `step_en`=1 and `advance`=0 (load) makes the next cycle show `burst_addr` = `start_addr` and `beat_idx` = 0.
- R3: A cycle with `step_en`=1 and `advance`=1 increments `beat_idx` modulo 4. On the fourth advance after a load, `burst_addr` is again the loaded start address. The `start_addr` input is ignored during advance cycles.
- R4: With `order_xor`=0, the low 2 bits of `burst_addr` equal (loaded low bits + `beat_idx`) mod 4. Example: a start of 2 gives 2, 3, 0, 1.
- R5: With `order_xor`=1, the low 2 bits of `burst_addr` equal the loaded low bits XOR `beat_idx`. Example: a start of 1 gives 1, 0, 3, 2.
- R6: A cycle with `step_en`=0 leaves `burst_addr` and `beat_idx` unchanged, whatever `advance`, `start_addr` and `order_xor` are.
- R7: Bits [ADDR_W-1:2] of `burst_addr` equal the same bits of the loaded start address throughout the burst. They are not carried into when the low bits wrap.
- R8: Advances that follow reset with no load continue from address 0. Under the linear order the low bits are then 1, 2, 3, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Clock enable; 0 freezes all state |
| advance | input | 1 | 0 loads `start_addr`, 1 steps to the next beat |
| order_xor | input | 1 | Burst order: 0 linear wrap, 1 XOR interleaved; static |
| start_addr | input | ADDR_W | External start address, captured on load |
| burst_addr | output | ADDR_W | Current burst address (registered) |
| beat_idx | output | BURST_LEN index width (2) | Beat number since the last load (registered) |

## Verification
The bench builds the block with ADDR_W = 6 and the default burst length of four. With these values all 64 start addresses can be swept under both orders. Every low-bit start is therefore combined with many upper-bit patterns, and each burst runs past its wrap point so that the return to the start and the untouched upper field are both observed. The bench also checks advances straight out of reset, and it checks frozen cycles in which the other inputs carry values different from the ones loaded.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             advance,
  output logic [IDX_W-1:0] beat_q,
  output logic [IDX_W-1:0] beat_nxt
);

  always_comb begin
    if (!advance) beat_nxt = '0;
    else          beat_nxt = IDX_W'(beat_q + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst)          beat_q <= '0;
    else if (step_en) beat_q <= beat_nxt;
  end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             order_xor,
  input  logic [IDX_W-1:0] base_lo,
  input  logic [IDX_W-1:0] beat,
  output logic [IDX_W-1:0] addr_lo
);

  logic [IDX_W-1:0] lin_lo;
  logic [IDX_W-1:0] xor_lo;

  assign lin_lo = IDX_W'(base_lo + beat);
  assign xor_lo = base_lo ^ beat;

  always_comb begin
    case (burst_order_e'(order_xor))
      ORD_XOR: addr_lo = xor_lo;
      default: addr_lo = lin_lo;
    endcase
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W    = 8,
  parameter int BURST_LEN = 4,
  localparam int IDX_W    = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              advance,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [IDX_W-1:0]  beat_idx
);

  localparam int HI_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_nxt;
  logic [IDX_W-1:0]  beat_nxt;
  logic [IDX_W-1:0]  lo_nxt;
  logic [HI_W-1:0]   hi_nxt;

  burst_beat_ctr #(.IDX_W(IDX_W)) u_beat (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .advance (advance),
    .beat_q  (beat_idx),
    .beat_nxt(beat_nxt)
  );

  assign base_nxt = advance ? base_q : start_addr;
  assign hi_nxt   = base_nxt[ADDR_W-1:IDX_W];

  burst_order_map #(.IDX_W(IDX_W)) u_map (
    .order_xor(order_xor),
    .base_lo  (base_nxt[IDX_W-1:0]),
    .beat     (beat_nxt),
    .addr_lo  (lo_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      burst_addr <= '0;
    end else if (step_en) begin
      base_q     <= base_nxt;
      burst_addr <= {hi_nxt, lo_nxt};
    end
  end

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W    = 8,
  parameter int BURST_LEN = 4,
  localparam int IDX_W    = $clog2(BURST_LEN)
) (
  input logic              clk,
  input logic              rst,
  input logic              step_en,
  input logic              advance,
  input logic              order_xor,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [IDX_W-1:0]  beat_idx
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (burst_addr == '0 && beat_idx == '0)); // R1

  AST_LOAD_TAKES_START: assert property (@(posedge clk) disable iff (rst)
    (step_en && !advance) |=> (burst_addr == $past(start_addr) && beat_idx == '0)); // R2

  AST_BEAT_STEPS: assert property (@(posedge clk) disable iff (rst)
    (step_en && advance) |=> (beat_idx == IDX_W'($past(beat_idx) + 1'b1))); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_en && advance && !order_xor) |=>
      (burst_addr[IDX_W-1:0] == IDX_W'($past(burst_addr[IDX_W-1:0]) + 1'b1))); // R4

  AST_XOR_BASE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (step_en && advance && order_xor && $stable(order_xor)) |=>
      ((burst_addr[IDX_W-1:0] ^ beat_idx) ==
       ($past(burst_addr[IDX_W-1:0]) ^ $past(beat_idx)))); // R5

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(burst_addr) && $stable(beat_idx))); // R6

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (step_en && advance) |=> $stable(burst_addr[ADDR_W-1:IDX_W])); // R7

endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .step_en   (step_en),
  .advance   (advance),
  .order_xor (order_xor),
  .start_addr(start_addr),
  .burst_addr(burst_addr),
  .beat_idx  (beat_idx)
);

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;

  localparam int AW = 6;
  localparam int BL = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_en = 1'b0;
  logic          advance = 1'b0;
  logic          order_xor = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] burst_addr;
  logic [IW-1:0] beat_idx;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_seq #(.ADDR_W(AW), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst(rst), .step_en(step_en), .advance(advance),
    .order_xor(order_xor), .start_addr(start_addr),
    .burst_addr(burst_addr), .beat_idx(beat_idx)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] st, int beat, logic ord);
    logic [IW-1:0] lo;
    if (ord) lo = st[IW-1:0] ^ IW'(beat % 4);
    else     lo = IW'((int'(st[IW-1:0]) + beat) % 4);
    return {st[AW-1:IW], lo};
  endfunction

  task automatic cycle(input logic ce, input logic adv, input logic ord, input logic [AW-1:0] st);
    @(negedge clk);
    step_en = ce; advance = adv; order_xor = ord; start_addr = st;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [AW-1:0] ea, input int eb);
    n_checks++;
    if (burst_addr !== ea || beat_idx !== IW'(eb)) begin
      n_errors++;
      $display("FAIL %s: addr=%0d beat=%0d expected addr=%0d beat=%0d",
               req, burst_addr, beat_idx, ea, eb % 4);
    end
  endtask

  initial begin
    cycle(1'b1, 1'b1, 1'b0, 6'h2A);
    cycle(1'b1, 1'b1, 1'b0, 6'h15);
    check("R1 reset state", '0, 0);
    rst = 1'b0;

    // R8: advances straight after reset start from 0, linear order
    for (int k = 1; k <= 5; k++) begin
      cycle(1'b1, 1'b1, 1'b0, 6'h3F);
      check("R8 advance without load", exp_addr('0, k, 1'b0), k % 4);
    end

    // R2 R3 R4 R5 R7: every start address under both orders, past the wrap
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 64; s++) begin
        cycle(1'b1, 1'b0, 1'(ord), AW'(s));
        check("R2 load", AW'(s), 0);
        for (int k = 1; k <= 5; k++) begin
          cycle(1'b1, 1'b1, 1'(ord), ~AW'(s));
          if (k == 4)
            check("R3 wrap to start", AW'(s), 0);
          else if (ord == 1)
            check("R5 interleaved with R7 upper bits", exp_addr(AW'(s), k, 1'b1), k % 4);
          else
            check("R4 linear with R7 upper bits", exp_addr(AW'(s), k, 1'b0), k % 4);
        end
      end
    end

    // R6: frozen cycles ignore load, advance and new start
    for (int ord = 0; ord < 2; ord++) begin
      cycle(1'b1, 1'b0, 1'(ord), 6'h2D);
      cycle(1'b1, 1'b1, 1'(ord), 6'h00);
      cycle(1'b1, 1'b1, 1'(ord), 6'h00);
      check("R6 before freeze", exp_addr(6'h2D, 2, 1'(ord)), 2);
      cycle(1'b0, 1'b0, 1'(ord), 6'h12);
      check("R6 frozen load ignored", exp_addr(6'h2D, 2, 1'(ord)), 2);
      cycle(1'b0, 1'b1, 1'(ord), 6'h12);
      check("R6 frozen advance ignored", exp_addr(6'h2D, 2, 1'(ord)), 2);
      cycle(1'b1, 1'b1, 1'(ord), 6'h12);
      check("R6 resume after freeze", exp_addr(6'h2D, 3, 1'(ord)), 3);
    end

    // R1 again: reset in mid-burst
    rst = 1'b1;
    cycle(1'b1, 1'b1, 1'b0, 6'h33);
    check("R1 reset mid-burst", '0, 0);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule